// File: doc/BRIEF.md
# Atomic Mux-Divider Clock Root

This block is a clock root that picks one of up to four source clocks and divides it by a ratio that may be a whole or a half-integer number. Software stages a new source index and divider code in a configuration register. Neither value reaches the clock path until software sets the commit bit in the command register. The block then applies both values in one step, so the output never runs at a frequency made from the old source with the new divider, or from the new source with the old divider.

A commit runs in four steps. The block stops the running source at a point where the output is low. It waits until every source gate reports closed. It loads the staged values into the active copy and restarts the divider. It then opens the gate of the new source and clears the commit bit. Each gate opens or closes only after its request has passed two rising edges of its own source, and always on a falling edge of that source. While no source drives the output, the output stays low and a status bit reports the root as off. Any source, including one that is always on at a fixed rate, can serve as an interim setting between two other settings.

Top module: `mux_div_root`

## Requirements
- R1: While reset is low the output stays low. After reset the command and configuration registers read 0, and the output follows source 0 undivided.
- R2: The command register is at byte offset 0x0 and the configuration register at 0x4. The source index sits in configuration bits [9:8] and the divider code D in bits [4:0]. The configuration register reads back the last written fields.
- R3: A configuration write changes only the staged copy. The output frequency stays the same, and command bit 4 (pending) reads 1 until a commit loads the staged copy.
- R4: Writing 1 to command bit 0 starts a commit. Bit 0 reads 1 until the new setting drives the output, then clears by itself. The time limit is 8 periods of the slower of the old and new sources, plus one output period of the old setting, plus 40 ns. Pending reads 0 after the commit.
- R5: Source and divider change together. The output shows no high or low pulse shorter than the shortest source half-period, and after a commit its period is exactly the period the new pair defines.
- R6: For D = 0 the output equals the selected source. For D >= 1 the output period is (D+1)/2 source periods, with the output high for floor((D+2)/2) source half-periods. Odd D therefore gives an integer ratio with a 50 % duty cycle.
- R7: At most one source gate is open at any time. Command bit 31 reads 1 while no source drives the output, which is always the case during a switch, and reads 0 once a source runs.
- R8: A command write with bit 0 clear starts nothing. Bit 0 stays 0, pending stays set and the output is unchanged.
- R9: A commit issued right after the previous one completes is applied in full, so a source-and-divider pair can be used as an interim setting between two others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, sampled on rising clk |
| bus_addr | input | 3 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_clk | input | 4 | Source clocks, one per index |
| clk_out | output | 1 | Root clock output |

## Verification
The divider is tried with four sources of different periods and with codes 0, 1, 2, 3, 4 and 5. Code 0 isolates the bypass path. Odd codes separate integer division with symmetric duty from the even codes, where the high phase must be one half-period longer than the low phase. Each commit measures both period and high time, so a wrong source, a wrong divider or a stale half of the pair gives a different value. A pulse-width monitor running through every switch catches a truncated pulse or a mixed frequency. A staged write without a commit and a command write with bit 0 clear show that nothing moves without the commit bit.

// File: rtl/mxd_pkg.sv
package mxd_pkg;
   // Byte offsets decoded by software
   localparam int unsigned CMD_OFS = 0;
   localparam int unsigned CFG_OFS = 4;
   // Command register bit positions
   localparam int unsigned CMD_COMMIT_BIT  = 0;
   localparam int unsigned CMD_PENDING_BIT = 4;
   localparam int unsigned CMD_OFF_BIT     = 31;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_DRAIN,
      ST_LOAD,
      ST_ARM
   } mxd_state_e;
endpackage

// File: rtl/mxd_ctrl.sv
module mxd_ctrl
   import mxd_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int SEL_W   = 2,
   parameter int SEL_LSB = 8,
   parameter int DIV_W   = 5,
   parameter int DIV_LSB = 0,
   parameter int ADDR_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] gate_open,
   output logic [NUM_SRC-1:0] src_req,
   output logic [SEL_W-1:0]   act_sel,
   output logic [DIV_W-1:0]   act_div,
   output logic               div_hold
);
   localparam logic [SEL_W:0] NSRC_V = (SEL_W+1)'(NUM_SRC);

   mxd_state_e         state, state_d;
   logic [SEL_W-1:0]   shd_sel, act_sel_q, load_sel;
   logic [DIV_W-1:0]   shd_div, act_div_q;
   logic               upd_q, pend_q, hold_q;
   logic [NUM_SRC-1:0] ack_s1, ack_s2, sel_oh;
   logic               cmd_hit, cfg_hit, new_on, root_off;
   logic               unused_wdata;

   assign unused_wdata = ^bus_wdata;
   assign cmd_hit  = bus_we && (bus_addr == ADDR_W'(CMD_OFS));
   assign cfg_hit  = bus_we && (bus_addr == ADDR_W'(CFG_OFS));
   assign root_off = (ack_s2 == '0);
   assign new_on   = |(ack_s2 & sel_oh);

   // Bring gate status back into the register clock domain
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_s1 <= '0;
         ack_s2 <= '0;
      end else begin
         ack_s1 <= gate_open;
         ack_s2 <= ack_s1;
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_oh
      assign sel_oh[i] = (act_sel_q == SEL_W'(i));
   end

   if (NUM_SRC < (1 << SEL_W)) begin : g_clamp
      assign load_sel = ({1'b0, shd_sel} < NSRC_V) ? shd_sel : '0;
   end else begin : g_full
      assign load_sel = shd_sel;
   end

   always_comb begin
      state_d = state;
      case (state)
         ST_IDLE:  if (upd_q) state_d = ST_DRAIN;
         ST_DRAIN: if (root_off) state_d = ST_LOAD;
         ST_LOAD:  state_d = ST_ARM;
         ST_ARM:   if (new_on) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         upd_q     <= 1'b0;
         pend_q    <= 1'b0;
         hold_q    <= 1'b1;
         shd_sel   <= '0;
         shd_div   <= '0;
         act_sel_q <= '0;
         act_div_q <= '0;
      end else begin
         state  <= state_d;
         hold_q <= (state_d == ST_LOAD) || (state == ST_LOAD);
         if (cfg_hit) begin
            shd_sel <= bus_wdata[SEL_LSB +: SEL_W];
            shd_div <= bus_wdata[DIV_LSB +: DIV_W];
         end
         if (cfg_hit) pend_q <= 1'b1;
         else if (state == ST_LOAD) pend_q <= 1'b0;
         if (state == ST_LOAD) begin
            act_sel_q <= load_sel;
            act_div_q <= shd_div;
         end
         if (state == ST_ARM && new_on) upd_q <= 1'b0;
         else if (cmd_hit && bus_wdata[CMD_COMMIT_BIT] && state == ST_IDLE) upd_q <= 1'b1;
      end
   end

   assign src_req  = (state == ST_IDLE || state == ST_ARM) ? sel_oh : '0;
   assign act_sel  = act_sel_q;
   assign act_div  = act_div_q;
   assign div_hold = hold_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(CMD_OFS)) begin
         bus_rdata[CMD_COMMIT_BIT]  = upd_q;
         bus_rdata[CMD_PENDING_BIT] = pend_q;
         bus_rdata[CMD_OFF_BIT]     = root_off;
      end else if (bus_addr == ADDR_W'(CFG_OFS)) begin
         bus_rdata[SEL_LSB +: SEL_W] = shd_sel;
         bus_rdata[DIV_LSB +: DIV_W] = shd_div;
      end
   end

   // R7: never two gates reported open together
   assert_single_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_s2));
   // R5: the active pair is only loaded once every gate is closed
   assert_drained_before_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOAD) |-> root_off);
   // R3: without a commit in flight the active pair does not move
   assert_active_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_q |=> ($stable(act_sel_q) && $stable(act_div_q)));
   // R4: the commit bit only clears once a source drives the output
   assert_commit_ends_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(upd_q) |-> !root_off);
endmodule

// File: rtl/mxd_switch.sv
module mxd_switch #(
   parameter int NUM_SRC = 4
) (
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_clk,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               may_stop,
   output logic [NUM_SRC-1:0] gate_open,
   output logic               gclk
);
   logic [NUM_SRC-1:0] gated;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
      logic s1, s2, en_q;
      // Two rising edges of the own source before the request counts
      always_ff @(posedge src_clk[i] or negedge rst_n) begin
         if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
         end else begin
            s1 <= src_req[i];
            s2 <= s1;
         end
      end
      // Gate changes only while the source is low; it closes only when
      // the divided output is in its low phase
      always_ff @(negedge src_clk[i] or negedge rst_n) begin
         if (!rst_n) en_q <= 1'b0;
         else        en_q <= s2 | (en_q & ~may_stop);
      end
      assign gate_open[i] = en_q;
      assign gated[i]     = src_clk[i] & en_q;
   end

   assign gclk = |gated;

   always_comb begin
      if (rst_n) begin
         assert_one_gate_R7: assert ($onehot0(gate_open));
      end
   end
endmodule

// File: rtl/mxd_hdiv.sv
module mxd_hdiv #(
   parameter int DIV_W = 5
) (
   input  logic             gclk,
   input  logic             arst,
   input  logic [DIV_W-1:0] div,
   output logic             may_stop,
   output logic             clk_out
);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] n_half, h_cnt, p_idx, n_idx;
   logic             p_tog, n_tog, bypass;

   assign n_half = CNT_W'(div) + CNT_W'(1);
   assign h_cnt  = (n_half + CNT_W'(1)) >> 1;
   assign bypass = (div == '0);

   function automatic logic [CNT_W-1:0] step2(input logic [CNT_W-1:0] idx,
                                              input logic [CNT_W-1:0] n);
      logic [CNT_W:0] s;
      s = {1'b0, idx} + (CNT_W+1)'(2);
      if (s >= {1'b0, n}) s = s - {1'b0, n};
      return s[CNT_W-1:0];
   endfunction

   // Half-periods starting on rising edges
   always_ff @(posedge gclk or posedge arst) begin
      if (arst) begin
         p_idx <= '0;
         p_tog <= 1'b0;
      end else begin
         if (p_idx == '0 || p_idx == h_cnt) p_tog <= ~p_tog;
         p_idx <= step2(p_idx, n_half);
      end
   end

   // Half-periods starting on falling edges
   always_ff @(negedge gclk or posedge arst) begin
      if (arst) begin
         n_idx <= CNT_W'(1);
         n_tog <= 1'b0;
      end else begin
         if (n_idx == '0 || n_idx == h_cnt) n_tog <= ~n_tog;
         n_idx <= step2(n_idx, n_half);
      end
   end

   assign may_stop = bypass || (n_idx >= h_cnt);
   assign clk_out  = bypass ? gclk : (p_tog ^ n_tog);

   // R6: the half-period position stays inside the programmed ratio
   assert_pos_idx_range_R6: assert property (@(posedge gclk) disable iff (arst || bypass)
      p_idx < n_half);
endmodule

// File: rtl/mux_div_root.sv
module mux_div_root #(
   parameter int NUM_SRC = 4,
   parameter int SEL_W   = 2,
   parameter int SEL_LSB = 8,
   parameter int DIV_W   = 5,
   parameter int DIV_LSB = 0,
   parameter int ADDR_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] src_clk,
   output logic               clk_out
);
   if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_nsrc
      $error("mux_div_root: NUM_SRC must lie in 1..4");
   end
   if (SEL_W < 1 || NUM_SRC > (1 << SEL_W)) begin : g_bad_selw
      $error("mux_div_root: SEL_W too narrow for NUM_SRC");
   end
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_divw
      $error("mux_div_root: DIV_W must lie in 1..16");
   end
   if (SEL_LSB + SEL_W > 31 || DIV_LSB + DIV_W > 31) begin : g_bad_fit
      $error("mux_div_root: configuration fields exceed the register");
   end
   if (!(SEL_LSB >= DIV_LSB + DIV_W || DIV_LSB >= SEL_LSB + SEL_W)) begin : g_bad_overlap
      $error("mux_div_root: configuration fields overlap");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("mux_div_root: ADDR_W must reach offset 0x4");
   end

   logic [NUM_SRC-1:0] src_req, gate_open;
   logic [SEL_W-1:0]   act_sel;
   logic [DIV_W-1:0]   act_div;
   logic               div_hold, may_stop, gclk, div_rst;
   logic               unused_sel;

   assign unused_sel = ^act_sel;
   assign div_rst    = !rst_n || div_hold;

   mxd_ctrl #(
      .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .SEL_LSB(SEL_LSB),
      .DIV_W(DIV_W), .DIV_LSB(DIV_LSB), .ADDR_W(ADDR_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gate_open(gate_open),
      .src_req(src_req), .act_sel(act_sel), .act_div(act_div), .div_hold(div_hold)
   );

   mxd_switch #(.NUM_SRC(NUM_SRC)) u_switch (
      .rst_n(rst_n), .src_clk(src_clk), .src_req(src_req),
      .may_stop(may_stop), .gate_open(gate_open), .gclk(gclk)
   );

   mxd_hdiv #(.DIV_W(DIV_W)) u_hdiv (
      .gclk(gclk), .arst(div_rst), .div(act_div),
      .may_stop(may_stop), .clk_out(clk_out)
   );
endmodule

// File: tb/mux_div_root_test.sv
`timescale 1ns/1ps
module mux_div_root_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
   logic [3:0]  src_clk;
   logic        clk_out;

   int n_chk = 0;
   int n_bad = 0;
   int glitches = 0;
   bit done = 0;
   int per_ns [4] = '{20, 30, 14, 50};
   int cur_src = 0;
   longint cur_out_ps = 20000;
   realtime last_rise = 0.0, last_fall = 0.0;

   assign src_clk = {s3, s2, s1, s0};

   always #2.5 clk = ~clk;
   always #10  s0 = ~s0;
   always #15  s1 = ~s1;
   always #7   s2 = ~s2;
   always #25  s3 = ~s3;

   mux_div_root uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_clk(src_clk),
      .clk_out(clk_out)
   );

   // Pulse-width monitor for R5: nothing shorter than the fastest half-period
   always @(posedge clk_out) begin
      if (rst_n && last_fall > 0.0 && ($realtime - last_fall) < 6.5) glitches++;
      last_rise = $realtime;
   end
   always @(negedge clk_out) begin
      if (rst_n && ($realtime - last_rise) < 6.5) glitches++;
      last_fall = $realtime;
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic longint exp_per(input int sel, input int dv);
      return (dv == 0) ? longint'(per_ns[sel]) * 1000 : longint'(per_ns[sel]) * 500 * (dv + 1);
   endfunction

   function automatic longint exp_hi(input int sel, input int dv);
      return (dv == 0) ? longint'(per_ns[sel]) * 500 : longint'((dv + 2) / 2) * per_ns[sel] * 500;
   endfunction

   task automatic measure(output longint per_ps, output longint hi_ps);
      realtime t0, t1, t2;
      repeat (2) @(posedge clk_out);
      @(posedge clk_out) t0 = $realtime;
      @(negedge clk_out) t1 = $realtime;
      @(posedge clk_out) t2 = $realtime;
      per_ps = longint'((t2 - t0) * 1000.0);
      hi_ps  = longint'((t1 - t0) * 1000.0);
   endtask

   task automatic check_rate(input int sel, input int dv, input string tag);
      longint p, h;
      measure(p, h);
      check(p == exp_per(sel, dv), {tag, " period"}, p, exp_per(sel, dv));
      check(h == exp_hi(sel, dv), {tag, " high time"}, h, exp_hi(sel, dv));
   endtask

   // Stage a pair, commit it, and check the commit handshake and the new rate
   task automatic apply(input int sel, input int dv, input string tag);
      logic [31:0] r;
      realtime ts;
      bit cleared = 0, saw_off = 0;
      longint el, bound;
      int slow;
      bus_write(3'h4, (32'(sel) << 8) | 32'(dv));
      bus_write(3'h0, 32'h1);
      ts = $realtime;
      for (int k = 0; k < 4000; k++) begin
         bus_read(3'h0, r);
         if (r[31]) saw_off = 1;
         if (!r[0]) begin cleared = 1; break; end
      end
      el = longint'(($realtime - ts) * 1000.0);
      slow = (per_ns[sel] > per_ns[cur_src]) ? per_ns[sel] : per_ns[cur_src];
      bound = longint'(slow) * 8000 + cur_out_ps + 40000;
      check(cleared && el <= bound, {tag, " R4 commit bit clears in time"}, el, bound);
      check(r[4] == 1'b0, {tag, " R4 pending cleared by commit"}, r[4], 0);
      check(saw_off, {tag, " R7 root reported off during switch"}, saw_off, 1);
      bus_read(3'h0, r);
      check(r[31] == 1'b0, {tag, " R7 root running after commit"}, r[31], 0);
      check_rate(sel, dv, {tag, " R5 R6"});
      cur_src = sel;
      cur_out_ps = exp_per(sel, dv);
   endtask

   task automatic t_reset;
      logic [31:0] r;
      bit seen_hi = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (clk_out) seen_hi = 1;
      end
      check(!seen_hi, "R1 output low during reset", seen_hi, 0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      bus_read(3'h0, r);
      check(r == 32'h0, "R1 command reads zero after reset", r, 0);
      bus_read(3'h4, r);
      check(r == 32'h0, "R1 configuration reads zero after reset", r, 0);
      check_rate(0, 0, "R1 source 0 undivided");
   endtask

   task automatic t_staged;
      logic [31:0] r;
      bus_write(3'h4, 32'h0000_0103);
      bus_read(3'h4, r);
      check(r == 32'h0000_0103, "R2 configuration readback", r, 32'h103);
      bus_read(3'h0, r);
      check(r[4] == 1'b1, "R3 pending set by staged write", r[4], 1);
      check(r[0] == 1'b0, "R3 no commit without command", r[0], 0);
      check_rate(0, 0, "R3 staged write leaves rate");
   endtask

   task automatic t_commit;
      logic [31:0] r;
      bus_write(3'h0, 32'h1);
      bus_read(3'h0, r);
      check(r[0] == 1'b1, "R4 commit bit reads set while busy", r[0], 1);
      for (int k = 0; k < 4000 && r[0]; k++) bus_read(3'h0, r);
      check(r[0] == 1'b0 && r[4] == 1'b0, "R4 commit completes", r[4:0], 0);
      check_rate(1, 3, "R5 R6 source 1 code 3");
      cur_src = 1;
      cur_out_ps = exp_per(1, 3);
   endtask

   task automatic t_ratios;
      apply(0, 2, "R6 source 0 code 2");
      apply(3, 4, "R6 source 3 code 4");
      apply(2, 0, "R6 source 2 bypass");
   endtask

   task automatic t_no_commit;
      logic [31:0] r;
      bus_write(3'h4, 32'h0000_0101);
      bus_write(3'h0, 32'h0000_0010);
      repeat (40) @(negedge clk);
      bus_read(3'h0, r);
      check(r[0] == 1'b0, "R8 command without bit 0 starts nothing", r[0], 0);
      check(r[4] == 1'b1, "R8 pending still set", r[4], 1);
      check_rate(2, 0, "R8 rate unchanged");
      apply(1, 1, "R6 source 1 code 1");
   endtask

   task automatic t_interim;
      apply(3, 1, "R9 interim always-on source");
      apply(0, 5, "R9 final setting after interim");
   endtask

   initial begin
      t_reset();
      t_staged();
      t_commit();
      t_ratios();
      t_no_commit();
      t_interim();
      check(glitches == 0, "R5 no short pulse across switches", glitches, 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule